// File: doc/BRIEF.md
# PTP Event Timestamp Holding Register

This block keeps the record of one time-synchronisation event packet until the host collects it. The record is the packet's 16-bit sequence ID and a 64-bit timestamp. A packet classifier upstream pulses a detect strobe with the sequence ID. A time counter supplies the current 64-bit time. The host reads and clears the record through a small register port. A status word holds the sequence ID and the flags, and two further words hold the lower and upper halves of the timestamp.

A parameter selects the direction. In the receive variant the sequence ID and the time are taken in the same cycle. In the transmit variant the detect strobe takes only the sequence ID and a request-source flag. The timestamp is taken later, when the egress path pulses an arrival strobe, and a pending flag covers the wait. The buffer is one entry deep, so only one event is held at a time. Detect strobes that arrive while the buffer is occupied are discarded and counted in a saturating drop counter.

Top module: `ptp_ts_capture_buf`

## Requirements
- R1: After reset the status word, both timestamp words and the drop count read as zero.
- R2: A write to address 0 with bit 16 of the write data set empties the buffer: the status word and both timestamp words read zero afterwards. A write to address 0 with bit 16 clear, or a write to any other address, changes nothing.
- R3: Transmit variant: a detect strobe on an empty buffer stores the sequence ID in status bits [15:0] and sets status bit 17 (pending), with status bit 16 (valid) clear.
- R4: Transmit variant: status bit 18 holds the request-source input sampled with the accepted detect strobe (1 = software request, 0 = hardware request).
- R5: Transmit variant: an arrival strobe while pending stores the current time as the timestamp, clears bit 17 and sets bit 16. An arrival strobe while not pending changes nothing.
- R6: Receive variant: a detect strobe on an empty buffer stores the sequence ID and the current time in the same cycle and sets bit 16 directly. Bits 17 and 18 stay zero.
- R7: A detect strobe while valid or pending is set leaves the record unchanged and adds one to the drop count. The count saturates at all ones.
- R8: Read address map: 0 = status word, 1 = timestamp bits [31:0], 2 = timestamp bits [63:32], 3 = drop count zero-extended to 32 bits.
- R9: When a clear write and a detect strobe fall in the same cycle on an occupied buffer, the clear takes effect and the detect is counted as dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| detect_i | input | 1 | Event packet detected strobe |
| seq_id_i | input | 16 | Sequence ID of the detected packet |
| sw_req_i | input | 1 | Request source of the detect (1 software, 0 hardware); used by the transmit variant only |
| ts_arrive_i | input | 1 | Egress timestamp arrival strobe; used by the transmit variant only |
| time_i | input | 64 | Current time value |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |

## Verification
The bench builds two instances with a 3-bit drop counter, one transmit and one receive. The narrow counter lets a loop of capture, overlap and clear cycles drive the transmit instance past saturation while the receive instance stays below it. Sequence IDs and 64-bit times are computed from the loop index so that both timestamp words and all sixteen ID bits change between iterations. Directed steps cover a stray arrival strobe, a write with the clear bit low, writes to the timestamp addresses, and a clear that coincides with a detect.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned SEQ_W    = 16;
  localparam int unsigned TIME_W   = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned VALID_B  = 16;
  localparam int unsigned PEND_B   = 17;
  localparam int unsigned SRC_B    = 18;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS = 2'd0,
    ADR_TS_LO  = 2'd1,
    ADR_TS_HI  = 2'd2,
    ADR_DROP   = 2'd3
  } cap_addr_e;
endpackage

// File: rtl/ptp_cap_ctrl.sv
module ptp_cap_ctrl #(
  parameter bit TX_SIDE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic detect_i,
  input  logic arrive_i,
  input  logic clr_i,
  output logic valid_o,
  output logic pend_o,
  output logic take_id_o,
  output logic take_time_o,
  output logic drop_o
);
  logic idle;
  assign idle      = !valid_o && !pend_o;
  assign take_id_o = detect_i && idle;
  assign drop_o    = detect_i && !idle;

  generate
    if (TX_SIDE) begin : g_tx
      assign take_time_o = arrive_i && pend_o && !clr_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o <= 1'b0;
          pend_o  <= 1'b0;
        end else if (take_id_o) begin
          pend_o  <= 1'b1;
        end else if (clr_i) begin
          valid_o <= 1'b0;
          pend_o  <= 1'b0;
        end else if (take_time_o) begin
          pend_o  <= 1'b0;
          valid_o <= 1'b1;
        end
      end

      a_r3_detect_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_id_o |=> pend_o && !valid_o);
      a_r5_arrival_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arrive_i && pend_o && !clr_i) |=> valid_o && !pend_o);
    end else begin : g_rx
      logic unused_arrive;
      assign unused_arrive = arrive_i;
      assign take_time_o   = take_id_o;
      assign pend_o        = 1'b0;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        valid_o <= 1'b0;
        else if (take_id_o) valid_o <= 1'b1;
        else if (clr_i)     valid_o <= 1'b0;
      end

      a_r6_rx_direct_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (detect_i && !valid_o) |=> valid_o);
    end
  endgenerate

  a_r5_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && pend_o));
  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !idle) |=> !valid_o && !pend_o);
endmodule

// File: rtl/ptp_cap_store.sv
module ptp_cap_store #(
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_id_i,
  input  logic              take_time_i,
  input  logic              clr_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic              src_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [SEQ_W-1:0]  seq_o,
  output logic              src_o,
  output logic [TIME_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_o <= '0;
      src_o <= 1'b0;
      ts_o  <= '0;
    end else if (clr_i && !take_id_i) begin
      seq_o <= '0;
      src_o <= 1'b0;
      ts_o  <= '0;
    end else begin
      if (take_id_i) begin
        seq_o <= seq_i;
        src_o <= src_i;
      end
      if (take_time_i) ts_o <= time_i;
    end
  end

  a_r7_id_held_without_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_id_i && !clr_i) |=> $stable(seq_o) && $stable(src_o));
endmodule

// File: rtl/ptp_cap_drop_cnt.sv
module ptp_cap_drop_cnt #(
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drop_i,
  output logic [DROP_W-1:0] cnt_o
);
  localparam logic [DROP_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (drop_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  a_r7_drop_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r7_drop_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/ptp_ts_capture_buf.sv
module ptp_ts_capture_buf
  import ptp_cap_pkg::*;
#(
  parameter bit          TX_SIDE = 1'b1,
  parameter int unsigned DROP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              detect_i,
  input  logic [SEQ_W-1:0]  seq_id_i,
  input  logic              sw_req_i,
  input  logic              ts_arrive_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  localparam int unsigned STAT_PAD = WORD_W - SRC_B - 1;
  localparam int unsigned DROP_PAD = WORD_W - DROP_W;

  logic valid, pend, take_id, take_time, drop, clr, src_in, src;
  logic [SEQ_W-1:0]  seq;
  logic [TIME_W-1:0] ts;
  logic [DROP_W-1:0] drop_cnt;
  logic              unused_wdata;

  assign clr          = reg_wr_i && (reg_addr_i == ADR_STATUS) && reg_wdata_i[VALID_B];
  assign unused_wdata = ^{reg_wdata_i[WORD_W-1:VALID_B+1], reg_wdata_i[VALID_B-1:0]};
  assign src_in       = TX_SIDE ? sw_req_i : 1'b0;

  ptp_cap_ctrl #(.TX_SIDE(TX_SIDE)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .detect_i    (detect_i),
    .arrive_i    (ts_arrive_i),
    .clr_i       (clr),
    .valid_o     (valid),
    .pend_o      (pend),
    .take_id_o   (take_id),
    .take_time_o (take_time),
    .drop_o      (drop)
  );

  ptp_cap_store #(.SEQ_W(SEQ_W), .TIME_W(TIME_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_id_i   (take_id),
    .take_time_i (take_time),
    .clr_i       (clr),
    .seq_i       (seq_id_i),
    .src_i       (src_in),
    .time_i      (time_i),
    .seq_o       (seq),
    .src_o       (src),
    .ts_o        (ts)
  );

  ptp_cap_drop_cnt #(.DROP_W(DROP_W)) u_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drop_i (drop),
    .cnt_o  (drop_cnt)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADR_STATUS: reg_rdata_o = {{STAT_PAD{1'b0}}, src, pend, valid, seq};
      ADR_TS_LO:  reg_rdata_o = ts[WORD_W-1:0];
      ADR_TS_HI:  reg_rdata_o = ts[TIME_W-1:WORD_W];
      default:    reg_rdata_o = {{DROP_PAD{1'b0}}, drop_cnt};
    endcase
  end

  a_r4_rx_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !TX_SIDE |-> !src && !pend);
  a_r2_empty_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !take_id) |=> ts == '0 && seq == '0);
endmodule

// File: tb/ptp_ts_capture_buf_bench.sv
module ptp_ts_capture_buf_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        t_det = 0, t_sw = 0, t_arr = 0, t_wr = 0;
  logic [15:0] t_seq = 0;
  logic [1:0]  t_addr = 0;
  logic [31:0] t_wd = 0, t_rd;
  logic        r_det = 0, r_wr = 0;
  logic [15:0] r_seq = 0;
  logic [1:0]  r_addr = 0;
  logic [31:0] r_wd = 0, r_rd;
  logic [63:0] tm = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  ptp_ts_capture_buf #(.TX_SIDE(1'b1), .DROP_W(3)) u_ptp_ts_capture_buf (
    .clk_i(clk), .rst_ni(rst_n), .detect_i(t_det), .seq_id_i(t_seq), .sw_req_i(t_sw),
    .ts_arrive_i(t_arr), .time_i(tm), .reg_addr_i(t_addr), .reg_wr_i(t_wr),
    .reg_wdata_i(t_wd), .reg_rdata_o(t_rd));

  ptp_ts_capture_buf #(.TX_SIDE(1'b0), .DROP_W(3)) u_ptp_ts_capture_buf_rx (
    .clk_i(clk), .rst_ni(rst_n), .detect_i(r_det), .seq_id_i(r_seq), .sw_req_i(1'b1),
    .ts_arrive_i(1'b1), .time_i(tm), .reg_addr_i(r_addr), .reg_wr_i(r_wr),
    .reg_wdata_i(r_wd), .reg_rdata_o(r_rd));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input bit rx, input logic [1:0] a, output logic [31:0] d);
    if (rx) r_addr = a; else t_addr = a;
    #1;
    d = rx ? r_rd : t_rd;
  endtask

  task automatic chk_rec(input bit rx, input string tag, input logic [31:0] st, input logic [63:0] ts);
    logic [31:0] d;
    rd(rx, 2'd0, d); chk({tag, " status"}, d, st);
    rd(rx, 2'd1, d); chk({tag, " ts_lo"}, d, ts[31:0]);
    rd(rx, 2'd2, d); chk({tag, " ts_hi"}, d, ts[63:32]);
  endtask

  // one clock: apply at negedge, release at next negedge (after posedge)
  task automatic tick;
    @(negedge clk);
    t_det = 0; t_arr = 0; t_wr = 0; r_det = 0; r_wr = 0;
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] ts_exp;
    int tdrop = 0, rdrop = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R8 address map
    chk_rec(0, "R1 tx reset", 32'h0, 64'h0);
    chk_rec(1, "R1 rx reset", 32'h0, 64'h0);
    rd(0, 2'd3, d); chk("R1 R8 tx drop reset", d, 0);
    rd(1, 2'd3, d); chk("R1 R8 rx drop reset", d, 0);

    // R5 stray arrival on empty buffer
    tm = 64'hDEAD_BEEF_0123_4567;
    t_arr = 1; tick;
    chk_rec(0, "R5 stray arrival", 32'h0, 64'h0);

    for (int k = 0; k < 8; k++) begin
      logic [15:0] sq;
      logic        sw;
      sq = 16'(k * 16'h1357 + 16'h0A0A);
      sw = k[0];
      // R3 R4 detect on empty
      t_seq = sq; t_sw = sw; t_det = 1; tm = 64'h1; tick;
      chk_rec(0, "R3 R4 tx detect", {13'd0, sw, 1'b1, 1'b0, sq}, 64'h0);
      // R7 detect while pending
      t_seq = ~sq; t_sw = ~sw; t_det = 1; tick;
      tdrop = (tdrop < 7) ? tdrop + 1 : 7;
      chk_rec(0, "R7 tx drop while pending", {13'd0, sw, 1'b1, 1'b0, sq}, 64'h0);
      rd(0, 2'd3, d); chk("R7 R8 tx drop count", d, 32'(tdrop));
      // R5 arrival
      ts_exp = {32'(k * 32'h0101_0101 + 32'h8000_0001), 32'(~(k * 32'h1111_2222))};
      tm = ts_exp; t_arr = 1; tick;
      tm = 64'h0;
      chk_rec(0, "R5 tx arrival", {13'd0, sw, 1'b0, 1'b1, sq}, ts_exp);
      // R7 detect while valid, plus second arrival ignored
      t_seq = 16'hFFFF; t_det = 1; t_arr = 1; tm = 64'h5555; tick;
      tdrop = (tdrop < 7) ? tdrop + 1 : 7;
      chk_rec(0, "R7 R5 tx ignore while valid", {13'd0, sw, 1'b0, 1'b1, sq}, ts_exp);
      rd(0, 2'd3, d); chk("R7 tx drop count sat", d, 32'(tdrop));
      // R2 ignored writes
      t_addr = 2'd0; t_wd = 32'hFFFE_FFFF; t_wr = 1; tick;
      t_addr = 2'd1; t_wd = 32'hFFFF_FFFF; t_wr = 1; tick;
      t_addr = 2'd2; t_wd = 32'hFFFF_FFFF; t_wr = 1; tick;
      chk_rec(0, "R2 tx no-clear writes", {13'd0, sw, 1'b0, 1'b1, sq}, ts_exp);
      // R2 clear
      t_addr = 2'd0; t_wd = 32'h0001_0000; t_wr = 1; tick;
      chk_rec(0, "R2 tx clear", 32'h0, 64'h0);

      // RX side (R6)
      ts_exp = {32'(k * 32'h0F0F_0F0F), 32'(k * 32'h2468_ACE1 + 32'h1)};
      r_seq = ~sq; r_det = 1; tm = ts_exp; tick;
      tm = 64'h0;
      chk_rec(1, "R6 rx capture", {15'd0, 1'b1, ~sq}, ts_exp);
      if (k < 4) begin
        r_seq = sq; r_det = 1; tm = 64'h77; tick;
        rdrop++;
        chk_rec(1, "R7 rx drop while valid", {15'd0, 1'b1, ~sq}, ts_exp);
      end
      rd(1, 2'd3, d); chk("R7 R8 rx drop count", d, 32'(rdrop));
      r_addr = 2'd0; r_wd = 32'h0001_0000; r_wr = 1; tick;
      chk_rec(1, "R2 rx clear", 32'h0, 64'h0);
    end

    // R9 clear together with detect on occupied buffer
    r_seq = 16'h1234; r_det = 1; tm = 64'hAB; tick;
    r_addr = 2'd0; r_wd = 32'h0001_0000; r_wr = 1; r_seq = 16'h5678; r_det = 1; tick;
    rdrop++;
    chk_rec(1, "R9 rx clear wins", 32'h0, 64'h0);
    rd(1, 2'd3, d); chk("R9 rx detect dropped", d, 32'(rdrop));
    t_seq = 16'h4321; t_sw = 1; t_det = 1; tick;
    t_addr = 2'd0; t_wd = 32'h0001_0000; t_wr = 1; t_arr = 1; t_det = 1; tm = 64'h99; tick;
    chk_rec(0, "R9 tx clear beats arrival and detect", 32'h0, 64'h0);
    // clear on empty with detect: capture proceeds
    r_addr = 2'd0; r_wd = 32'h0001_0000; r_wr = 1; r_seq = 16'h00C3; r_det = 1; tm = 64'h0000_0002_0000_0003; tick;
    chk_rec(1, "R9 R6 rx empty clear with detect", 32'h0001_00C3, 64'h0000_0002_0000_0003);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule